// File: doc/BRIEF.md
# Compartment-Tagged Translation Lookaside Buffer

This block is a fully associative address-translation cache in which every entry belongs to one software compartment. Each entry holds a virtual page number, a physical page number, read/write/execute rights, a 5-bit compartment identifier, and two protection flags: an integrity flag and an encryption flag. The cache uses these flags to tag the line. A current-compartment register names the compartment that is running. A lookup succeeds only when an entry matches the virtual page **and** carries the current compartment's identifier **and** grants the requested access. When the page is present but only under other identifiers, the block reports a distinct compartment-mismatch miss. That miss hands control to the hypervisor so it can check and perform a compartment transition.

The hypervisor writes entries through the fill port, typically while it handles a miss. The same virtual page may live in several entries under different identifiers, each with its own physical page and rights, so compartments can share memory. Identifier 0 is the reset value of the current-compartment register and stands for all unprotected software.

Lookups flow through a valid/ready request channel and a valid/ready result channel:
- A request is accepted when `lk_valid` and `lk_ready` are both high.
- Its result appears on the next cycle.
- `lk_ready` is high whenever the result slot is empty or is being drained in the same cycle.
- A result held under back-pressure stays unchanged until `res_ready` takes it.

The fill port and the current-compartment write are plain strobes.

Top module: `ctag_tlb`

## Requirements
- R1: After reset no entry is valid, `cur_cid` is 0, `res_valid` is 0, and every lookup reports kind 1 (no page).
- R2: A lookup whose page matches an entry with identifier equal to `cur_cid` and whose access is granted reports kind 0 (hit), with that entry's physical page, integrity flag and encryption flag.
- R3: A lookup whose page matches one or more entries, none with identifier equal to `cur_cid`, reports kind 2 (compartment mismatch).
- R4: A lookup whose page matches no valid entry reports kind 1.
- R5: Access codes are 0 read, 1 write, 2 execute and 3 reserved. Rights bits are bit0 read, bit1 write and bit2 execute. An owned page whose rights lack the requested access, or any reserved access, reports kind 3 (permission).
- R6: Entries for the same page under different identifiers coexist. Each compartment sees only its own entry's physical page and rights.
- R7: A fill whose page and identifier both equal those of a valid entry overwrites that entry in place and uses no new slot.
- R8: Any other fill takes the lowest-numbered empty slot. When all slots are full, it replaces the slot named by a round-robin pointer. The pointer starts at 0 and advances by one, wrapping, after each such replacement.
- R9: A write of the current compartment applies to lookups accepted in later cycles. A lookup accepted in the same cycle uses the old value. A fill in the same cycle as a lookup is not seen by that lookup.
- R10: `lk_ready` equals `!res_valid || res_ready`. Each accepted request yields exactly one result, one cycle later. A result stalled by `res_ready` low stays valid and unchanged.
- R11: For any result other than a hit, `res_ppn`, `res_integ` and `res_crypt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted when high |
| lk_vpn | input | 20 | Virtual page to translate |
| lk_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result consumer ready |
| res_kind | output | 2 | 0 hit, 1 no page, 2 compartment mismatch, 3 permission |
| res_ppn | output | 24 | Physical page on hit, else 0 |
| res_integ | output | 1 | Integrity flag on hit, else 0 |
| res_crypt | output | 1 | Encryption flag on hit, else 0 |
| fill_en | input | 1 | Write an entry this cycle |
| fill_vpn | input | 20 | Entry virtual page |
| fill_ppn | input | 24 | Entry physical page |
| fill_cid | input | 5 | Entry compartment identifier |
| fill_rights | input | 3 | Entry rights: bit0 read, bit1 write, bit2 execute |
| fill_integ | input | 1 | Entry integrity flag |
| fill_crypt | input | 1 | Entry encryption flag |
| cur_we | input | 1 | Load the current-compartment register |
| cur_wcid | input | 5 | New current compartment |
| cur_cid | output | 5 | Current compartment |

## Verification
The bench covers these corner cases, and what a wrong design would do in each:
- **Shared page under two identifiers.** A design that took the first address match, regardless of tag, would return the other compartment's physical page or rights.
- **Page present only under foreign identifiers.** A design that merged this case into the plain miss would report kind 1 where kind 2 is due.
- **Eviction order.** Fills continue past a full array, and the lookups that follow show which page disappeared. A pointer that moved on in-place overwrites, or did not wrap, would evict the wrong page.
- **Same-cycle updates.** A compartment write in the same cycle as a lookup shows whether a design wrongly lets the new value bypass into that lookup.
- **Back-pressure.** Stalled results expose a design that drops or alters a held response.

// File: rtl/ctlb_pkg.sv
package ctlb_pkg;

  typedef enum logic [1:0] {
    LK_HIT     = 2'd0,
    LK_NOPAGE  = 2'd1,
    LK_FOREIGN = 2'd2,
    LK_DENIED  = 2'd3
  } lk_kind_e;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  localparam int RIGHT_R = 0;
  localparam int RIGHT_W = 1;
  localparam int RIGHT_X = 2;

endpackage

// File: rtl/ctlb_store.sv
module ctlb_store #(
  parameter int N     = 8,
  parameter int VPN_W = 20,
  parameter int PPN_W = 24,
  parameter int CID_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [CID_W-1:0] fill_cid,
  input  logic [2:0]       fill_rights,
  input  logic             fill_integ,
  input  logic             fill_crypt,
  output logic [N-1:0]     ent_valid,
  output logic [VPN_W-1:0] ent_vpn    [N],
  output logic [PPN_W-1:0] ent_ppn    [N],
  output logic [CID_W-1:0] ent_cid    [N],
  output logic [2:0]       ent_rights [N],
  output logic [N-1:0]     ent_integ,
  output logic [N-1:0]     ent_crypt
);

  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic [IDX_W-1:0] rr_ptr;
  logic [IDX_W-1:0] dup_idx, free_idx, tgt_idx;
  logic             dup_found, free_found, replacing;

  // Slot choice: same page+compartment first, then lowest empty, else pointer
  always_comb begin
    dup_found  = 1'b0;
    free_found = 1'b0;
    dup_idx    = '0;
    free_idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (!dup_found && ent_valid[i] && ent_vpn[i] == fill_vpn && ent_cid[i] == fill_cid) begin
        dup_found = 1'b1;
        dup_idx   = IDX_W'(i);
      end
      if (!free_found && !ent_valid[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
    replacing = !dup_found && !free_found;
    tgt_idx   = dup_found ? dup_idx : (free_found ? free_idx : rr_ptr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_ptr    <= '0;
      ent_valid <= '0;
      ent_integ <= '0;
      ent_crypt <= '0;
      for (int i = 0; i < N; i++) begin
        ent_vpn[i]    <= '0;
        ent_ppn[i]    <= '0;
        ent_cid[i]    <= '0;
        ent_rights[i] <= '0;
      end
    end else if (fill_en) begin
      ent_valid[tgt_idx]  <= 1'b1;
      ent_vpn[tgt_idx]    <= fill_vpn;
      ent_ppn[tgt_idx]    <= fill_ppn;
      ent_cid[tgt_idx]    <= fill_cid;
      ent_rights[tgt_idx] <= fill_rights;
      ent_integ[tgt_idx]  <= fill_integ;
      ent_crypt[tgt_idx]  <= fill_crypt;
      if (replacing) rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
    end
  end

  AST_VALID_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(ent_valid) >= $past($countones(ent_valid))); // R8
  AST_RR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fill_en || !(&ent_valid)) |=> rr_ptr == $past(rr_ptr)); // R8

endmodule

// File: rtl/ctlb_match.sv
module ctlb_match
  import ctlb_pkg::*;
#(
  parameter int N     = 8,
  parameter int VPN_W = 20,
  parameter int PPN_W = 24,
  parameter int CID_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     ent_valid,
  input  logic [VPN_W-1:0] ent_vpn    [N],
  input  logic [PPN_W-1:0] ent_ppn    [N],
  input  logic [CID_W-1:0] ent_cid    [N],
  input  logic [2:0]       ent_rights [N],
  input  logic [N-1:0]     ent_integ,
  input  logic [N-1:0]     ent_crypt,
  input  logic [VPN_W-1:0] look_vpn,
  input  logic [1:0]       look_acc,
  input  logic [CID_W-1:0] cur_cid,
  output logic [1:0]       m_kind,
  output logic [PPN_W-1:0] m_ppn,
  output logic             m_integ,
  output logic             m_crypt
);

  logic [N-1:0] addr_hit, own_hit;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign addr_hit[g] = ent_valid[g] && (ent_vpn[g] == look_vpn);
    assign own_hit[g]  = addr_hit[g] && (ent_cid[g] == cur_cid);
  end

  logic [PPN_W-1:0] sel_ppn;
  logic [2:0]       sel_rights;
  logic             sel_integ, sel_crypt, allowed;

  always_comb begin
    sel_ppn    = '0;
    sel_rights = '0;
    sel_integ  = 1'b0;
    sel_crypt  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (own_hit[i]) begin
        sel_ppn    = sel_ppn | ent_ppn[i];
        sel_rights = sel_rights | ent_rights[i];
        sel_integ  = sel_integ | ent_integ[i];
        sel_crypt  = sel_crypt | ent_crypt[i];
      end
    end
    case (look_acc)
      ACC_READ:  allowed = sel_rights[RIGHT_R];
      ACC_WRITE: allowed = sel_rights[RIGHT_W];
      ACC_EXEC:  allowed = sel_rights[RIGHT_X];
      default:   allowed = 1'b0;
    endcase
    if (!(|addr_hit))     m_kind = LK_NOPAGE;
    else if (!(|own_hit)) m_kind = LK_FOREIGN;
    else if (!allowed)    m_kind = LK_DENIED;
    else                  m_kind = LK_HIT;
    m_ppn   = (m_kind == LK_HIT) ? sel_ppn : '0;
    m_integ = (m_kind == LK_HIT) && sel_integ;
    m_crypt = (m_kind == LK_HIT) && sel_crypt;
  end

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(own_hit)); // R7

endmodule

// File: rtl/ctag_tlb.sv
module ctag_tlb
  import ctlb_pkg::*;
#(
  parameter int N     = 8,
  parameter int VPN_W = 20,
  parameter int PPN_W = 24,
  parameter int CID_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [1:0]       lk_acc,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [1:0]       res_kind,
  output logic [PPN_W-1:0] res_ppn,
  output logic             res_integ,
  output logic             res_crypt,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [CID_W-1:0] fill_cid,
  input  logic [2:0]       fill_rights,
  input  logic             fill_integ,
  input  logic             fill_crypt,
  input  logic             cur_we,
  input  logic [CID_W-1:0] cur_wcid,
  output logic [CID_W-1:0] cur_cid
);

  logic [N-1:0]     ent_valid, ent_integ, ent_crypt;
  logic [VPN_W-1:0] ent_vpn    [N];
  logic [PPN_W-1:0] ent_ppn    [N];
  logic [CID_W-1:0] ent_cid    [N];
  logic [2:0]       ent_rights [N];

  logic [1:0]       m_kind;
  logic [PPN_W-1:0] m_ppn;
  logic             m_integ, m_crypt;

  ctlb_store #(.N(N), .VPN_W(VPN_W), .PPN_W(PPN_W), .CID_W(CID_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_cid(fill_cid),
    .fill_rights(fill_rights), .fill_integ(fill_integ), .fill_crypt(fill_crypt),
    .ent_valid(ent_valid), .ent_vpn(ent_vpn), .ent_ppn(ent_ppn), .ent_cid(ent_cid),
    .ent_rights(ent_rights), .ent_integ(ent_integ), .ent_crypt(ent_crypt)
  );

  ctlb_match #(.N(N), .VPN_W(VPN_W), .PPN_W(PPN_W), .CID_W(CID_W)) u_match (
    .clk(clk), .rst_n(rst_n),
    .ent_valid(ent_valid), .ent_vpn(ent_vpn), .ent_ppn(ent_ppn), .ent_cid(ent_cid),
    .ent_rights(ent_rights), .ent_integ(ent_integ), .ent_crypt(ent_crypt),
    .look_vpn(lk_vpn), .look_acc(lk_acc), .cur_cid(cur_cid),
    .m_kind(m_kind), .m_ppn(m_ppn), .m_integ(m_integ), .m_crypt(m_crypt)
  );

  // Current compartment; 0 means unprotected software
  always_ff @(posedge clk) begin
    if (!rst_n)      cur_cid <= '0;
    else if (cur_we) cur_cid <= cur_wcid;
  end

  assign lk_ready = !res_valid || res_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_kind  <= LK_NOPAGE;
      res_ppn   <= '0;
      res_integ <= 1'b0;
      res_crypt <= 1'b0;
    end else if (lk_valid && lk_ready) begin
      res_valid <= 1'b1;
      res_kind  <= m_kind;
      res_ppn   <= m_ppn;
      res_integ <= m_integ;
      res_crypt <= m_crypt;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> res_valid && $stable(res_kind) && $stable(res_ppn)); // R10
  AST_ACCEPT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> res_valid); // R10
  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind != LK_HIT) |-> (res_ppn == '0 && !res_integ && !res_crypt)); // R11
  AST_CUR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cur_we |=> cur_cid == $past(cur_wcid)); // R9

endmodule

// File: tb/tb_ctag_tlb.sv
module tb_ctag_tlb;
  localparam int N = 8;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        lk_valid = 0, res_ready = 1;
  logic        lk_ready, res_valid, res_integ, res_crypt;
  logic [19:0] lk_vpn = 0, fill_vpn = 0;
  logic [1:0]  lk_acc = 0, res_kind;
  logic [23:0] res_ppn, fill_ppn = 0;
  logic        fill_en = 0, fill_integ = 0, fill_crypt = 0, cur_we = 0;
  logic [4:0]  fill_cid = 0, cur_wcid = 0, cur_cid;
  logic [2:0]  fill_rights = 0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  ctag_tlb dut (.*);

  // behavioural reference state
  bit          m_v [N];
  logic [19:0] m_vpn [N];
  logic [23:0] m_ppn [N];
  logic [4:0]  m_cid [N];
  logic [2:0]  m_rt [N];
  bit          m_i [N], m_c [N];
  int          m_rr, m_cur;
  bit          e_valid;
  int          e_kind;
  logic [23:0] e_ppn;
  bit          e_i, e_c;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_lookup(logic [19:0] vpn, logic [1:0] acc);
    bit addr = 0;
    int own = -1;
    bit ok;
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_vpn[i] == vpn) begin
        addr = 1;
        if (m_cid[i] == m_cur) own = i;
      end
    e_ppn = 0; e_i = 0; e_c = 0;
    if (!addr) e_kind = 1;
    else if (own < 0) e_kind = 2;
    else begin
      ok = (acc == 0) ? m_rt[own][0] : (acc == 1) ? m_rt[own][1] : (acc == 2) ? m_rt[own][2] : 1'b0;
      if (!ok) e_kind = 3;
      else begin e_kind = 0; e_ppn = m_ppn[own]; e_i = m_i[own]; e_c = m_c[own]; end
    end
  endtask

  task automatic model_fill();
    int slot = -1;
    for (int i = 0; i < N; i++)
      if (slot < 0 && m_v[i] && m_vpn[i] == fill_vpn && m_cid[i] == fill_cid) slot = i;
    if (slot < 0)
      for (int i = 0; i < N; i++) if (slot < 0 && !m_v[i]) slot = i;
    if (slot < 0) begin slot = m_rr; m_rr = (m_rr + 1) % N; end
    m_v[slot] = 1; m_vpn[slot] = fill_vpn; m_ppn[slot] = fill_ppn; m_cid[slot] = fill_cid;
    m_rt[slot] = fill_rights; m_i[slot] = fill_integ; m_c[slot] = fill_crypt;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
      m_rr = 0; m_cur = 0; e_valid = 0;
    end else begin
      if (lk_valid && (!e_valid || res_ready)) begin
        model_lookup(lk_vpn, lk_acc);
        e_valid = 1;
      end else if (res_ready) e_valid = 0;
      if (fill_en) model_fill();
      if (cur_we) m_cur = cur_wcid;
    end
  end

  // per-cycle comparison, away from the driving edge
  initial forever begin
    @(posedge clk); #2;
    if (rst_n && !done) begin
      chk(lk_ready == (!e_valid || res_ready), "R10", "lk_ready", lk_ready, !e_valid || res_ready);
      chk(res_valid == e_valid, "R10", "res_valid", res_valid, e_valid);
      chk(cur_cid == m_cur[4:0], "R9", "cur_cid", cur_cid, m_cur);
      if (e_valid && res_valid) begin
        chk(res_kind == e_kind[1:0], (e_kind == 0) ? "R2" : (e_kind == 1) ? "R4" : (e_kind == 2) ? "R3" : "R5",
            "res_kind", res_kind, e_kind);
        chk(res_ppn == e_ppn && res_integ == e_i && res_crypt == e_c,
            (e_kind == 0) ? "R2" : "R11", "ppn/flags", {res_ppn, res_integ, res_crypt}, {e_ppn, e_i, e_c});
      end
    end
  end

  task automatic fill(logic [19:0] v, logic [23:0] p, logic [4:0] c, logic [2:0] r, bit i, bit e);
    @(negedge clk);
    fill_en = 1; fill_vpn = v; fill_ppn = p; fill_cid = c; fill_rights = r; fill_integ = i; fill_crypt = e;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic set_cur(logic [4:0] c);
    @(negedge clk); cur_we = 1; cur_wcid = c;
    @(negedge clk); cur_we = 0;
  endtask

  task automatic look(logic [19:0] v, logic [1:0] a, int kind, logic [23:0] ppn, string req);
    @(negedge clk); lk_valid = 1; lk_vpn = v; lk_acc = a;
    @(negedge clk); lk_valid = 0;
    chk(res_valid == 1, req, "directed valid", res_valid, 1);
    chk(res_kind == kind[1:0], req, "directed kind", res_kind, kind);
    chk(res_ppn == ppn, req, "directed ppn", res_ppn, ppn);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(res_valid == 0 && lk_ready == 1 && cur_cid == 0, "R1", "reset state",
        {res_valid, lk_ready, cur_cid}, 7'b0100000);
    look(20'h100, 0, 1, 0, "R1");
    fill(20'h100, 24'hA, 0, 3'b001, 0, 0);
    look(20'h100, 0, 0, 24'hA, "R2");
    look(20'h100, 1, 3, 0, "R5");
    look(20'h100, 2, 3, 0, "R5");
    look(20'h100, 3, 3, 0, "R5");
    look(20'h555, 0, 1, 0, "R4");
    fill(20'h200, 24'hB, 3, 3'b111, 1, 1);
    look(20'h200, 0, 2, 0, "R3");
    set_cur(3);
    look(20'h200, 2, 0, 24'hB, "R9");
    chk(res_integ && res_crypt, "R2", "flags", {res_integ, res_crypt}, 2'b11);
    look(20'h100, 0, 2, 0, "R3");
    fill(20'h200, 24'hC, 0, 3'b001, 0, 1);
    look(20'h200, 1, 0, 24'hB, "R6");
    set_cur(0);
    look(20'h200, 1, 3, 0, "R6");
    look(20'h200, 0, 0, 24'hC, "R6");
    set_cur(3);
    fill(20'h200, 24'hD, 3, 3'b001, 0, 0);
    look(20'h200, 0, 0, 24'hD, "R7");
    look(20'h200, 1, 3, 0, "R7");
    for (int k = 0; k < 5; k++) fill(20'h300 + 20'(k), 24'h30 + 24'(k), 3, 3'b001, 0, 0);
    look(20'h304, 0, 0, 24'h34, "R8");
    fill(20'h400, 24'h40, 0, 3'b001, 0, 0);
    set_cur(0);
    look(20'h100, 0, 1, 0, "R8");
    fill(20'h401, 24'h41, 0, 3'b001, 0, 0);
    set_cur(3);
    look(20'h200, 0, 2, 0, "R8");
    look(20'h300, 0, 0, 24'h30, "R8");
    // same-cycle compartment write and lookup: old compartment applies
    @(negedge clk); lk_valid = 1; lk_vpn = 20'h300; lk_acc = 0; cur_we = 1; cur_wcid = 0;
    @(negedge clk); lk_valid = 0; cur_we = 0;
    chk(res_kind == 0 && res_ppn == 24'h30, "R9", "old cur used", res_kind, 0);
    look(20'h300, 0, 2, 0, "R9");
    // back-pressure
    @(negedge clk); res_ready = 0; lk_valid = 1; lk_vpn = 20'h400; lk_acc = 0;
    @(negedge clk); lk_vpn = 20'h401;
    @(negedge clk);
    chk(lk_ready == 0 && res_valid == 1 && res_ppn == 24'h40, "R10", "stall hold", {lk_ready, res_ppn}, 24'h40);
    @(negedge clk); res_ready = 1;
    @(negedge clk); lk_valid = 0;
    chk(res_valid == 1 && res_ppn == 24'h41, "R10", "second result", res_ppn, 24'h41);
    // random mixed traffic
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      lk_valid    = ($urandom % 3) != 0;
      lk_vpn      = 20'h10 + 20'($urandom % 4);
      lk_acc      = 2'($urandom);
      res_ready   = ($urandom % 4) != 0;
      fill_en     = ($urandom % 4) == 0;
      fill_vpn    = 20'h10 + 20'($urandom % 6);
      fill_ppn    = 24'($urandom);
      fill_cid    = 5'($urandom % 4);
      fill_rights = 3'($urandom);
      fill_integ  = 1'($urandom);
      fill_crypt  = 1'($urandom);
      cur_we      = ($urandom % 8) == 0;
      cur_wcid    = 5'($urandom % 4);
    end
    @(negedge clk);
    lk_valid = 0; fill_en = 0; cur_we = 0; res_ready = 1;
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule